// File: doc/BRIEF.md
# Stereo Audio Serial Port Master

This block is the clock master of a two-channel digital audio link. It receives a master clock that runs at 256 times the sample rate. From it, the block derives a bit clock and a frame clock, so the sample rate always follows the master clock and has no setting of its own. On each frame the block shifts out a 16-bit left and right sample pair on the serial output. At the same time it assembles the pair that arrives on the serial input.

The parallel side uses a single per-frame strobe. Both transfers happen on the master clock edge that raises the strobe:

- The sample pair received during the previous frame is presented on the parallel outputs.
- The pair waiting on the parallel inputs is captured for transmission.

The host only has to change its transmit pair between strobes. It reads the received pair in the strobe cycle or at any time before the next strobe.

Top module: `audio_serial_master`

## Requirements
- R1: `bclk` has a period of 8 `clk` cycles. After reset is released it is low for the first 4 cycles and high for the next 4, and the pattern then repeats.
- R2: A frame is 32 bit-clock periods long. `lrclk` is low during bit periods 0 to 15 (the left slot) and high during bit periods 16 to 31 (the right slot). It changes only together with a falling edge of `bclk`.
- R3: `so` carries the frame word {left, right}, two's complement and most significant bit first. It changes only on falling edges of `bclk`. Bit period n of the frame carries word bit 31-n, so each slot's MSB appears with the `lrclk` edge that starts the slot. The values 0x8000 and 0x7FFF pass unaltered.
- R4: `si` is sampled once per bit period, on the rising edge of `bclk`. The 32 bits of a frame, MSB first, form {rx_left, rx_right}.
- R5: `frame_stb` is high for exactly one `clk` cycle per frame. That cycle is the first cycle of the next frame, in which `lrclk` has just fallen. `rx_left`/`rx_right` take the previous frame's received pair in that cycle and hold it until the next strobe.
- R6: `tx_left`/`tx_right` are sampled only on the `clk` edge that raises `frame_stb`. The sampled pair is sent in the frame that begins there. Values present on these inputs at any other time have no effect on `so`. The first frame after reset sends all zeros.
- R7: `rst` is synchronous and active high. While it is sampled high, `bclk`, `lrclk`, `so` and `frame_stb` are low and `rx_left`/`rx_right` are zero. On release, timing restarts from bit period 0 of a left slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 256 times the sample rate |
| rst | input | 1 | Synchronous active-high reset; holds the link quiet |
| tx_left | input | 16 | Left sample to transmit, captured at the strobe edge |
| tx_right | input | 16 | Right sample to transmit, captured at the strobe edge |
| si | input | 1 | Serial data input, sampled on rising `bclk` |
| bclk | output | 1 | Bit clock, `clk` divided by 8 |
| lrclk | output | 1 | Frame clock: low = left slot, high = right slot |
| so | output | 1 | Serial data output, changes on falling `bclk` |
| frame_stb | output | 1 | One-cycle strobe at the start of each frame |
| rx_left | output | 16 | Left sample received in the previous frame |
| rx_right | output | 16 | Right sample received in the previous frame |

## Verification
The assertions rely on `rst` being held for at least one `clk` edge before it is released. They also rely on a master clock that never stops, so every bit period spans exactly 8 `clk` cycles. They place no constraint on `si` or on the transmit inputs.

The stimulus changes `si` only in the low phase of `clk`. It rewrites the transmit pair twice per frame: first with a decoy right after the strobe, then with the real value well before the next strobe. Every output is compared against arithmetic predictions in every `clk` cycle across several frames. This is repeated after a reset applied in the middle of a frame.

// File: rtl/aspm_pkg.sv
package aspm_pkg;

    parameter int unsigned SAMPLE_W      = 16;
    parameter int unsigned MCLK_PER_BCLK = 8;

    typedef enum logic {
        SLOT_LEFT  = 1'b0,
        SLOT_RIGHT = 1'b1
    } slot_e;

    typedef struct packed {
        logic rise;       // bit clock about to rise: capture point
        logic fall;       // bit clock about to fall: launch point
        logic frame_end;  // last fall of the frame
    } bit_tick_t;

    function automatic int unsigned frame_bits(input int unsigned w);
        return 2 * w;
    endfunction

endpackage

// File: rtl/aspm_clkgen.sv
module aspm_clkgen
    import aspm_pkg::*;
#(
    parameter int unsigned DIV        = 8,   // even, power of two
    parameter int unsigned FRAME_BITS = 32   // power of two
) (
    input  logic      clk,
    input  logic      rst,
    output logic      bclk,
    output slot_e     slot,
    output bit_tick_t tick
);

    localparam int unsigned DW   = (DIV > 2) ? $clog2(DIV) : 1;
    localparam int unsigned HALF = DIV / 2;
    localparam int unsigned BW   = $clog2(FRAME_BITS);

    logic [DW-1:0] div_q;
    logic [DW-1:0] div_d;
    logic [BW-1:0] bit_q;

    always_comb begin
        div_d          = (div_q == DW'(DIV - 1)) ? '0 : div_q + 1'b1;
        tick.rise      = (div_q == DW'(HALF - 1));
        tick.fall      = (div_q == DW'(DIV - 1));
        tick.frame_end = tick.fall && (bit_q == BW'(FRAME_BITS - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
            bit_q <= '0;
            bclk  <= 1'b0;
        end else begin
            div_q <= div_d;
            bclk  <= (div_d >= DW'(HALF));
            if (tick.fall) begin
                bit_q <= tick.frame_end ? '0 : bit_q + 1'b1;
            end
        end
    end

    assign slot = slot_e'(bit_q[BW-1]);

    // R1: bit clock toggles only at the half-period boundaries
    a_r1_bclk_boundary: assert property (@(posedge clk) disable iff (rst)
        !$stable(bclk) |-> (div_q == '0 || div_q == DW'(HALF)));

    // R2: slot changes only with a falling bit clock
    a_r2_slot_on_fall: assert property (@(posedge clk) disable iff (rst)
        !$stable(slot) |-> $fell(bclk));

endmodule

// File: rtl/aspm_tx.sv
module aspm_tx
    import aspm_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  bit_tick_t    tick,
    input  logic         bclk,
    input  logic [W-1:0] left,
    input  logic [W-1:0] right,
    output logic         so
);

    localparam int unsigned FW = frame_bits(W);

    logic [FW-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
        end else if (tick.frame_end) begin
            sh_q <= {left, right};
        end else if (tick.fall) begin
            sh_q <= {sh_q[FW-2:0], 1'b0};
        end
    end

    assign so = sh_q[FW-1];

    // R3: serial output only moves with a falling bit clock
    a_r3_so_on_fall: assert property (@(posedge clk) disable iff (rst)
        !$stable(so) |-> $fell(bclk));

endmodule

// File: rtl/aspm_rx.sv
module aspm_rx
    import aspm_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  bit_tick_t    tick,
    input  logic         si,
    output logic [W-1:0] left,
    output logic [W-1:0] right,
    output logic         stb
);

    localparam int unsigned FW = frame_bits(W);

    logic [FW-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q  <= '0;
            left  <= '0;
            right <= '0;
            stb   <= 1'b0;
        end else begin
            stb <= tick.frame_end;
            if (tick.rise) begin
                sh_q <= {sh_q[FW-2:0], si};
            end
            if (tick.frame_end) begin
                left  <= sh_q[FW-1:W];
                right <= sh_q[W-1:0];
            end
        end
    end

    // R5: strobe lasts a single cycle
    a_r5_stb_single: assert property (@(posedge clk) disable iff (rst)
        stb |=> !stb);

    // R5: received pair holds between strobes
    a_r5_rx_hold: assert property (@(posedge clk) disable iff (rst)
        !stb |-> ($stable(left) && $stable(right)));

endmodule

// File: rtl/audio_serial_master.sv
module audio_serial_master
    import aspm_pkg::*;
#(
    parameter int unsigned SLOT_W = aspm_pkg::SAMPLE_W,
    parameter int unsigned DIV    = aspm_pkg::MCLK_PER_BCLK
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SLOT_W-1:0] tx_left,
    input  logic [SLOT_W-1:0] tx_right,
    input  logic              si,
    output logic              bclk,
    output logic              lrclk,
    output logic              so,
    output logic              frame_stb,
    output logic [SLOT_W-1:0] rx_left,
    output logic [SLOT_W-1:0] rx_right
);

    localparam int unsigned FRAME_BITS = frame_bits(SLOT_W);

    bit_tick_t tick;
    slot_e     slot;

    aspm_clkgen #(.DIV(DIV), .FRAME_BITS(FRAME_BITS)) u_clkgen (
        .clk  (clk),
        .rst  (rst),
        .bclk (bclk),
        .slot (slot),
        .tick (tick)
    );

    aspm_tx #(.W(SLOT_W)) u_tx (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .bclk  (bclk),
        .left  (tx_left),
        .right (tx_right),
        .so    (so)
    );

    aspm_rx #(.W(SLOT_W)) u_rx (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .si    (si),
        .left  (rx_left),
        .right (rx_right),
        .stb   (frame_stb)
    );

    assign lrclk = (slot == SLOT_RIGHT);

    // R5: strobe marks the start of a left slot, right after the right slot
    a_r5_stb_frame_start: assert property (@(posedge clk) disable iff (rst)
        frame_stb |-> (!lrclk && !bclk && $past(lrclk)));

    // R7: reset leaves the link quiet
    a_r7_reset_quiet: assert property (@(posedge clk)
        rst |=> (!bclk && !lrclk && !so && !frame_stb
                 && rx_left == '0 && rx_right == '0));

endmodule

// File: tb/audio_serial_master_tb.sv
`timescale 1ns/1ps
module audio_serial_master_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] tx_left = '0;
    logic [15:0] tx_right = '0;
    logic        si = 1'b0;
    logic        bclk, lrclk, so, frame_stb;
    logic [15:0] rx_left, rx_right;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    audio_serial_master u_dut (
        .clk(clk), .rst(rst), .tx_left(tx_left), .tx_right(tx_right), .si(si),
        .bclk(bclk), .lrclk(lrclk), .so(so), .frame_stb(frame_stb),
        .rx_left(rx_left), .rx_right(rx_right)
    );

    function automatic logic [15:0] pat(input int f, input int s);
        if (f == 1) return (s % 2 == 0) ? 16'h8000 : 16'h7FFF;
        if (f == 2) return (s % 2 == 0) ? 16'h7FFF : 16'h8000;
        return 16'(f * 16'h3B5D + s * 16'h1234 + 16'h00A5);
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    // R7: hold reset for a few cycles, check the quiet state, release at a negedge
    task automatic do_reset(input int cycles);
        rst = 1'b1;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            chk("R7", "bclk", 32'(bclk), 32'd0);
            chk("R7", "lrclk", 32'(lrclk), 32'd0);
            chk("R7", "so", 32'(so), 32'd0);
            chk("R7", "frame_stb", 32'(frame_stb), 32'd0);
            chk("R7", "rx", {rx_left, rx_right}, 32'd0);
        end
        rst = 1'b0;
    endtask

    // Runs `cycles` clk cycles from reset release, checking every cycle
    task automatic run(input int cycles, input int salt);
        tx_left  = pat(1, salt);
        tx_right = pat(1, salt + 1);
        for (int k = 0; k < cycles; k++) begin
            int f, b, ph;
            logic [31:0] txw, siw, rxw;
            f  = k / 256;
            b  = (k / 8) % 32;
            ph = k % 8;
            txw = (f == 0) ? 32'd0 : {pat(f, salt), pat(f, salt + 1)};
            siw = {pat(f, salt + 2), pat(f, salt + 3)};
            rxw = (f == 0) ? 32'd0 : {pat(f - 1, salt + 2), pat(f - 1, salt + 3)};
            chk("R1", "bclk", 32'(bclk), 32'(ph >= 4));
            chk("R2", "lrclk", 32'(lrclk), 32'(b >= 16));
            chk((f == 0) ? "R6" : "R3", "so", 32'(so), 32'(txw[31 - b]));
            chk("R5", "frame_stb", 32'(frame_stb), 32'(k % 256 == 0 && k > 0));
            chk("R4", "rx pair", {rx_left, rx_right}, rxw);
            si = siw[31 - b];
            // R6: decoy right after the load edge, real pair well before the next one
            if (k % 256 == 0) begin
                tx_left  = ~pat(f + 1, salt);
                tx_right = ~pat(f + 1, salt + 1);
            end else if (k % 256 == 200) begin
                tx_left  = pat(f + 1, salt);
                tx_right = pat(f + 1, salt + 1);
            end
            @(negedge clk);
        end
    endtask

    initial begin
        do_reset(6);
        run(4 * 256 + 100, 0);   // ends mid-frame
        do_reset(4);
        run(3 * 256 + 8, 5);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule